// File: doc/BRIEF.md
# Dual-Strobe Parallel Host Mailbox Port

This block is the slave side of an 8-bit parallel host port in a signal-processor subsystem. An external host reaches a small register set over a byte-wide bus with a two-bit address. It writes command bytes into the mailbox and reads outbound bytes and a status byte. A static mode input selects one of two strobe conventions. The first uses separate active-low read and write strobes under chip select. The second uses a single active-low data strobe and a read/write direction line under chip select.

All host strobe, address and data pins pass through a two-flop synchronizer into the core clock before edges are detected. A host write takes effect when its strobe is released. An inbound message byte is handed to the core as a one-cycle valid pulse and sets an inbound flag, which the core clears with an acknowledge. The core places outbound bytes one at a time into a single holding register, marking the final byte of each message. An active-low interrupt line stays asserted from the first queued byte until the host has read the byte marked final, so the core can also announce messages the host never asked for. Read data is driven straight from the registers whenever a read is active at a readable address. The bus output enable is low whenever chip select is high.

Top module: `hpi_mailbox`

## Requirements
- R1: `mode_moto`=0 selects separate strobes: a read is `hcs_n`=0 with `hrd_n`=0, and a write is `hcs_n`=0 with `hwr_n`=0. `mode_moto`=1 selects a shared data strobe: a read is `hcs_n`=0, `hds_n`=0 and `hrw`=1, and a write is the same with `hrw`=0.
- R2: During an active read at address 0 (message) or address 1 (status), `hdata_oe` is 1 and `hdata_out` carries the selected register.
- R3: `hdata_oe` is 0 whenever `hcs_n` is 1, and during any read at address 2 or 3.
- R4: A host write to address 0 is captured when its strobe is released. `msg_in_byte` then shows the written byte with exactly one single-cycle `msg_in_valid` pulse per write.
- R5: A host write to address 2 produces exactly one single-cycle `pcm_valid` pulse with the byte on `pcm_byte`, and no `msg_in_valid` pulse.
- R6: Host writes to address 1 or 3 have no effect: they raise no pulse and leave the status byte unchanged.
- R7: The status byte at address 1 has these fields. Bit 0 is set while an outbound byte is waiting. Bit 1 is the inbound flag. Bit 2 is the final-byte mark of the waiting byte. Bits 7:3 are zero.
- R8: `core_out_ready` is 1 only while the holding register is empty. A `core_out_valid` offered while it is full is dropped, and the held byte is kept.
- R9: `host_irq_n` goes low when the core queues a byte, with or without a prior host request. It returns high only after the host has finished reading a byte marked final. A read of a non-final byte leaves it low.
- R10: The end of a host read at address 0 empties the holding register, clearing status bit 0. Reading the status byte changes nothing.
- R11: A message write sets the inbound flag, and `msg_in_ack` clears it. When both fall in the same cycle, the flag ends up set.
- R12: After reset, `host_irq_n`=1, `hdata_oe`=0, `core_out_ready`=1, no valid pulses occur, and the status byte reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_moto | input | 1 | Strobe convention select (0 separate strobes, 1 data strobe with direction) |
| hcs_n | input | 1 | Host chip select, active low |
| hrd_n | input | 1 | Host read strobe, active low (mode 0) |
| hwr_n | input | 1 | Host write strobe, active low (mode 0) |
| hds_n | input | 1 | Host data strobe, active low (mode 1) |
| hrw | input | 1 | Host direction, 1 read, 0 write (mode 1) |
| haddr | input | 2 | Host register address |
| hdata_in | input | 8 | Host write data |
| hdata_out | output | 8 | Host read data |
| hdata_oe | output | 1 | Bus drive enable for hdata_out |
| host_irq_n | output | 1 | Outbound message pending, active low |
| msg_in_byte | output | 8 | Last inbound message byte |
| msg_in_valid | output | 1 | One-cycle pulse on a new inbound byte |
| msg_in_ack | input | 1 | Core consumed the inbound byte |
| pcm_byte | output | 8 | Last byte written to the PCM address |
| pcm_valid | output | 1 | One-cycle pulse on a new PCM byte |
| core_out_byte | input | 8 | Outbound byte from the core |
| core_out_last | input | 1 | Outbound byte is the last of its message |
| core_out_valid | input | 1 | Core offers an outbound byte |
| core_out_ready | output | 1 | Holding register empty, offer accepted |

## Verification
One collision is a host message write whose synchronized strobe release lands in the same core cycle as the core's acknowledge of the previous byte. The bench provokes it by counting the two synchronizer edges after it releases the write strobe and raising `msg_in_ack` for exactly the cycle in which the capture registers. The status byte must then show the inbound flag set, with the new byte on `msg_in_byte`. The second collision is a core offer that meets a full holding register while the host has not yet read. The result is judged by `core_out_ready` being low and the next host read returning the older byte.

// File: rtl/hpi_mbx_pkg.sv
package hpi_mbx_pkg;
  localparam int unsigned DATA_W = 8;
  localparam int unsigned ADDR_W = 2;

  localparam logic [ADDR_W-1:0] A_MSG = 2'b00;
  localparam logic [ADDR_W-1:0] A_CTL = 2'b01;
  localparam logic [ADDR_W-1:0] A_PCM = 2'b10;

  // strobe-release events in the core domain
  typedef struct packed {
    logic              wr_end;
    logic              rd_end;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } host_evt_t;
endpackage

// File: rtl/hpi_sync.sv
module hpi_sync #(
  parameter int unsigned W      = 8,
  parameter int unsigned STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [STAGES-1:0][W-1:0] stg_q, stg_d;

  always_comb begin
    stg_d = {stg_q[STAGES-2:0], d};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg_q <= {STAGES{RST_VAL}};
    else        stg_q <= stg_d;
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/hpi_strobe_decode.sv
module hpi_strobe_decode
  import hpi_mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_moto,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              wr_n,
  input  logic              ds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] data,
  output host_evt_t         evt
);
  logic              rd_act, wr_act;
  logic              rd_q, wr_q, rd_d, wr_d;
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [DATA_W-1:0] data_q, data_d;

  always_comb begin
    rd_act = !cs_n && (mode_moto ? (!ds_n && rw)  : !rd_n);
    wr_act = !cs_n && (mode_moto ? (!ds_n && !rw) : !wr_n);
    rd_d   = rd_act;
    wr_d   = wr_act;
    addr_d = (rd_act || wr_act) ? addr : addr_q;
    data_d = wr_act ? data : data_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_q   <= 1'b0;
      wr_q   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      rd_q   <= rd_d;
      wr_q   <= wr_d;
      addr_q <= addr_d;
      data_q <= data_d;
    end
  end

  always_comb begin
    evt.wr_end = wr_q && !wr_act;
    evt.rd_end = rd_q && !rd_act;
    evt.addr   = addr_q;
    evt.data   = data_q;
  end

  // R1
  rd_wr_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_q && wr_q));
endmodule

// File: rtl/hpi_mailbox_regs.sv
module hpi_mailbox_regs
  import hpi_mbx_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  host_evt_t         evt,
  output logic [DATA_W-1:0] out_byte,
  output logic [DATA_W-1:0] ctl_byte,
  output logic              host_irq_n,
  output logic [DATA_W-1:0] msg_in_byte,
  output logic              msg_in_valid,
  input  logic              msg_in_ack,
  output logic [DATA_W-1:0] pcm_byte,
  output logic              pcm_valid,
  input  logic [DATA_W-1:0] core_out_byte,
  input  logic              core_out_last,
  input  logic              core_out_valid,
  output logic              core_out_ready
);
  logic              full_q, full_d, last_q, last_d, pend_q, pend_d;
  logic              inf_q, inf_d, inv_q, inv_d, pcv_q, pcv_d;
  logic [DATA_W-1:0] ob_q, ob_d, ib_q, ib_d, pb_q, pb_d;
  logic              push, pop, wr_msg, wr_pcm;

  always_comb begin
    push   = core_out_valid && !full_q;
    pop    = evt.rd_end && (evt.addr == A_MSG) && full_q;
    wr_msg = evt.wr_end && (evt.addr == A_MSG);
    wr_pcm = evt.wr_end && (evt.addr == A_PCM);

    full_d = push ? 1'b1 : (pop ? 1'b0 : full_q);
    ob_d   = push ? core_out_byte : ob_q;
    last_d = push ? core_out_last : last_q;
    pend_d = push ? 1'b1 : ((pop && last_q) ? 1'b0 : pend_q);

    inv_d  = wr_msg;
    ib_d   = wr_msg ? evt.data : ib_q;
    inf_d  = wr_msg ? 1'b1 : (msg_in_ack ? 1'b0 : inf_q);
    pcv_d  = wr_pcm;
    pb_d   = wr_pcm ? evt.data : pb_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      full_q <= 1'b0; last_q <= 1'b0; pend_q <= 1'b0;
      inf_q  <= 1'b0; inv_q  <= 1'b0; pcv_q  <= 1'b0;
      ob_q   <= '0;   ib_q   <= '0;   pb_q   <= '0;
    end else begin
      full_q <= full_d; last_q <= last_d; pend_q <= pend_d;
      inf_q  <= inf_d;  inv_q  <= inv_d;  pcv_q  <= pcv_d;
      ob_q   <= ob_d;   ib_q   <= ib_d;   pb_q   <= pb_d;
    end
  end

  assign out_byte       = ob_q;
  assign ctl_byte       = {{(DATA_W-3){1'b0}}, last_q, inf_q, full_q};
  assign host_irq_n     = !pend_q;
  assign msg_in_byte    = ib_q;
  assign msg_in_valid   = inv_q;
  assign pcm_byte       = pb_q;
  assign pcm_valid      = pcv_q;
  assign core_out_ready = !full_q;

  // R4
  msg_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_in_valid |=> !msg_in_valid);
  // R5
  pcm_msg_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(msg_in_valid && pcm_valid));
  // R11
  inflag_on_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    msg_in_valid |-> ctl_byte[1]);
  // R9
  irq_on_push_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (core_out_valid && core_out_ready) |=> (!host_irq_n && !core_out_ready));
  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(host_irq_n) |-> core_out_ready);
  // R8
  hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!core_out_ready && !evt.rd_end) |=> $stable(out_byte));
endmodule

// File: rtl/hpi_mailbox.sv
module hpi_mailbox
  import hpi_mbx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              mode_moto,
  input  logic              hcs_n,
  input  logic              hrd_n,
  input  logic              hwr_n,
  input  logic              hds_n,
  input  logic              hrw,
  input  logic [ADDR_W-1:0] haddr,
  input  logic [DATA_W-1:0] hdata_in,
  output logic [DATA_W-1:0] hdata_out,
  output logic              hdata_oe,
  output logic              host_irq_n,
  output logic [DATA_W-1:0] msg_in_byte,
  output logic              msg_in_valid,
  input  logic              msg_in_ack,
  output logic [DATA_W-1:0] pcm_byte,
  output logic              pcm_valid,
  input  logic [DATA_W-1:0] core_out_byte,
  input  logic              core_out_last,
  input  logic              core_out_valid,
  output logic              core_out_ready
);
  localparam int unsigned BW = 5 + ADDR_W + DATA_W;
  localparam logic [BW-1:0] BUS_IDLE = {5'b11111, {(ADDR_W+DATA_W){1'b0}}};

  logic [1:0]        rst_pipe_q;
  logic              rst_core_n;
  logic [BW-1:0]     bus_raw, bus_s;
  host_evt_t         evt;
  logic [DATA_W-1:0] out_byte, ctl_byte;
  logic              rd_raw;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe_q <= 2'b00;
    else        rst_pipe_q <= {rst_pipe_q[0], 1'b1};
  end
  assign rst_core_n = rst_pipe_q[1];

  assign bus_raw = {hcs_n, hrd_n, hwr_n, hds_n, hrw, haddr, hdata_in};

  hpi_sync #(.W(BW), .STAGES(SYNC_STAGES), .RST_VAL(BUS_IDLE)) u_sync (
    .clk(clk), .rst_n(rst_core_n), .d(bus_raw), .q(bus_s)
  );

  hpi_strobe_decode u_dec (
    .clk(clk), .rst_n(rst_core_n), .mode_moto(mode_moto),
    .cs_n(bus_s[BW-1]), .rd_n(bus_s[BW-2]), .wr_n(bus_s[BW-3]),
    .ds_n(bus_s[BW-4]), .rw(bus_s[BW-5]),
    .addr(bus_s[ADDR_W+DATA_W-1:DATA_W]), .data(bus_s[DATA_W-1:0]),
    .evt(evt)
  );

  hpi_mailbox_regs u_regs (
    .clk(clk), .rst_n(rst_core_n), .evt(evt),
    .out_byte(out_byte), .ctl_byte(ctl_byte), .host_irq_n(host_irq_n),
    .msg_in_byte(msg_in_byte), .msg_in_valid(msg_in_valid), .msg_in_ack(msg_in_ack),
    .pcm_byte(pcm_byte), .pcm_valid(pcm_valid),
    .core_out_byte(core_out_byte), .core_out_last(core_out_last),
    .core_out_valid(core_out_valid), .core_out_ready(core_out_ready)
  );

  // read path is combinational from the pins so data is valid within the strobe
  always_comb begin
    rd_raw    = !hcs_n && (mode_moto ? (!hds_n && hrw) : !hrd_n);
    hdata_oe  = rd_raw && (haddr == A_MSG || haddr == A_CTL);
    hdata_out = !hdata_oe ? '0 : ((haddr == A_CTL) ? ctl_byte : out_byte);
  end

  // R3
  no_drive_deselected_chk: assert property (@(posedge clk) disable iff (!rst_core_n)
    hcs_n |-> !hdata_oe);
endmodule

// File: tb/hpi_mailbox_tb.sv
`timescale 1ns/1ps
module hpi_mailbox_tb;
  logic clk = 1'b0;
  logic rst_n;
  logic mode_moto, hcs_n, hrd_n, hwr_n, hds_n, hrw;
  logic [1:0] haddr;
  logic [7:0] hdata_in, hdata_out, msg_in_byte, pcm_byte, core_out_byte;
  logic hdata_oe, host_irq_n, msg_in_valid, msg_in_ack, pcm_valid;
  logic core_out_last, core_out_valid, core_out_ready;

  int checks = 0, failures = 0;
  int in_cnt = 0, pcm_cnt = 0;
  logic [7:0] in_seen = 8'h00, pcm_seen = 8'h00;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  hpi_mailbox u_dut (
    .clk(clk), .rst_n(rst_n), .mode_moto(mode_moto), .hcs_n(hcs_n), .hrd_n(hrd_n),
    .hwr_n(hwr_n), .hds_n(hds_n), .hrw(hrw), .haddr(haddr), .hdata_in(hdata_in),
    .hdata_out(hdata_out), .hdata_oe(hdata_oe), .host_irq_n(host_irq_n),
    .msg_in_byte(msg_in_byte), .msg_in_valid(msg_in_valid), .msg_in_ack(msg_in_ack),
    .pcm_byte(pcm_byte), .pcm_valid(pcm_valid), .core_out_byte(core_out_byte),
    .core_out_last(core_out_last), .core_out_valid(core_out_valid),
    .core_out_ready(core_out_ready)
  );

  always @(negedge clk) begin
    if (msg_in_valid) begin in_cnt++; in_seen = msg_in_byte; end
    if (pcm_valid)    begin pcm_cnt++; pcm_seen = pcm_byte; end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic strobe_on(input bit m, input bit rd);
    mode_moto = m; hcs_n = 1'b0;
    if (m) begin hrw = rd; hds_n = 1'b0; end
    else if (rd) hrd_n = 1'b0;
    else hwr_n = 1'b0;
  endtask

  task automatic strobe_off();
    hcs_n = 1'b1; hrd_n = 1'b1; hwr_n = 1'b1; hds_n = 1'b1; hrw = 1'b1;
  endtask

  task automatic host_write(input bit m, input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); haddr = a; hdata_in = d; strobe_on(m, 1'b0);
    wait_n(4); strobe_off(); wait_n(6);
  endtask

  task automatic host_read(input bit m, input logic [1:0] a,
                           output logic [7:0] d, output logic oe);
    @(negedge clk); haddr = a; strobe_on(m, 1'b1);
    wait_n(4); d = hdata_out; oe = hdata_oe; strobe_off(); wait_n(6);
  endtask

  task automatic push(input logic [7:0] b, input bit last, output bit rdy);
    @(negedge clk); core_out_byte = b; core_out_last = last; core_out_valid = 1'b1;
    rdy = core_out_ready;
    @(negedge clk); core_out_valid = 1'b0;
    wait_n(1);
  endtask

  task automatic ack();
    @(negedge clk); msg_in_ack = 1'b1; @(negedge clk); msg_in_ack = 1'b0; wait_n(1);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      failures++; checks++;
      $display("FAIL watchdog actual=0x0 expected=0x1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    logic [7:0] d; logic oe; bit rdy; int pc, ic;
    rst_n = 1'b0; mode_moto = 1'b0; strobe_off(); haddr = 2'b00; hdata_in = 8'h00;
    msg_in_ack = 1'b0; core_out_byte = 8'h00; core_out_last = 1'b0; core_out_valid = 1'b0;
    wait_n(5); rst_n = 1'b1; wait_n(5);

    // R12 reset state
    chk(host_irq_n == 1'b1, "R12 irq", host_irq_n, 1);
    chk(hdata_oe == 1'b0, "R12 oe", hdata_oe, 0);
    chk(core_out_ready == 1'b1, "R12 ready", core_out_ready, 1);
    chk(in_cnt == 0 && pcm_cnt == 0, "R12 pulses", in_cnt + pcm_cnt, 0);
    host_read(1'b0, 2'b01, d, oe);
    chk(oe && d == 8'h00, "R12 status", d, 0);

    // R1 R4 R11: message write sweep in both modes
    for (int m = 0; m < 2; m++) begin
      for (int v = 0; v < 256; v++) begin
        ic = in_cnt;
        host_write(m[0], 2'b00, v[7:0]);
        chk(in_cnt == ic + 1 && in_seen == v[7:0], "R1 R4 msg write", in_seen, v);
      end
      host_read(m[0], 2'b01, d, oe);
      chk(oe && d == 8'h02, "R11 R7 inbound flag set", d, 2);
      ack();
      host_read(m[0], 2'b01, d, oe);
      chk(oe && d == 8'h00, "R11 ack clears", d, 0);
    end

    // R5: PCM write sweep, modes alternating
    for (int v = 0; v < 256; v++) begin
      ic = in_cnt; pc = pcm_cnt;
      host_write(v[0], 2'b10, 8'(v ^ 8'h5A));
      chk(pcm_cnt == pc + 1 && in_cnt == ic && pcm_seen == 8'(v ^ 8'h5A),
          "R5 pcm write", pcm_seen, v ^ 8'h5A);
    end

    // R6: writes to status and unused address
    for (int m = 0; m < 2; m++) begin
      ic = in_cnt; pc = pcm_cnt;
      host_write(m[0], 2'b01, 8'hFF);
      host_write(m[0], 2'b11, 8'hA5);
      chk(in_cnt == ic && pcm_cnt == pc, "R6 no pulse", in_cnt - ic + pcm_cnt - pc, 0);
      host_read(m[0], 2'b01, d, oe);
      chk(oe && d == 8'h00, "R6 status unchanged", d, 0);
    end

    // R3: unreadable addresses and deselected bus
    for (int m = 0; m < 2; m++) begin
      host_read(m[0], 2'b10, d, oe);
      chk(!oe, "R3 addr 2 read", oe, 0);
      host_read(m[0], 2'b11, d, oe);
      chk(!oe, "R3 addr 3 read", oe, 0);
    end
    @(negedge clk); hrd_n = 1'b0; haddr = 2'b00; mode_moto = 1'b0; wait_n(2);
    chk(!hdata_oe, "R3 cs high intel", hdata_oe, 0);
    hrd_n = 1'b1; mode_moto = 1'b1; hds_n = 1'b0; hrw = 1'b1; wait_n(2);
    chk(!hdata_oe, "R3 cs high moto", hdata_oe, 0);
    strobe_off(); wait_n(2);

    // R2 R7 R8 R9 R10: outbound messages of three bytes, unsolicited
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 3; k++) begin
        logic [7:0] b; bit lst;
        b = 8'(8'h30 + k * 7 + m * 64); lst = (k == 2);
        push(b, lst, rdy);
        chk(rdy, "R8 ready when empty", rdy, 1);
        chk(host_irq_n == 1'b0, "R9 irq on queue", host_irq_n, 0);
        host_read(m[0], 2'b01, d, oe);
        chk(oe && d == 8'(lst * 4 + 1), "R7 status fields", d, lst * 4 + 1);
        host_read(m[0], 2'b01, d, oe);
        chk(d == 8'(lst * 4 + 1), "R10 status read no effect", d, lst * 4 + 1);
        host_read(m[0], 2'b00, d, oe);
        chk(oe && d == b, "R2 message read", d, b);
        host_read(m[0], 2'b01, d, oe);
        chk(d[0] == 1'b0, "R10 pop clears bit0", d[0], 0);
        chk(host_irq_n == lst, "R9 irq after read", host_irq_n, lst);
      end
    end

    // R8: offer while full is dropped
    push(8'hC3, 1'b1, rdy);
    push(8'h3C, 1'b0, rdy);
    chk(!rdy, "R8 not ready when full", rdy, 0);
    host_read(1'b0, 2'b00, d, oe);
    chk(d == 8'hC3, "R8 held byte kept", d, 8'hC3);
    chk(host_irq_n == 1'b1, "R9 irq released", host_irq_n, 1);

    // R11: write capture and ack in the same cycle
    host_write(1'b0, 2'b00, 8'h11);
    ack();
    @(negedge clk); haddr = 2'b00; hdata_in = 8'h77; strobe_on(1'b0, 1'b0);
    wait_n(4); strobe_off();
    @(posedge clk); @(posedge clk); @(negedge clk); msg_in_ack = 1'b1;
    @(negedge clk); msg_in_ack = 1'b0; wait_n(4);
    host_read(1'b0, 2'b01, d, oe);
    chk(d[1] == 1'b1, "R11 set wins over ack", d[1], 1);
    chk(in_seen == 8'h77, "R11 new byte", in_seen, 8'h77);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule